// File: doc/BRIEF.md
# RSS Key and Indirection Table Loader

This block holds the secret hash key and the channel indirection table of a receive-side-scaling engine, and it gives a host a small register port through which both are loaded. One data register serves both memories. The host puts a value into the data register. It then writes the command register, which selects the target memory, gives the entry index, picks a write or a read-back, and raises the start flag. The start flag reads back as a busy flag. It stays set for a fixed number of cycles and then clears by itself, which marks the point where storage has been updated and the host may issue the next command.

The key is 40 bytes long and is loaded as ten 32-bit words. Each word holds four consecutive key bytes, with the lowest-numbered byte in the least significant byte lane. The table has 128 entries, and each entry holds a 4-bit DMA channel number. A third register holds four enables that the hash engine reads. The hash engine sees the whole key as a flat vector and reads the table through its own read port, which is independent of the host path.

Top module: `rss_prog_port`

## Requirements
- R1: After reset every register reads zero, `key_o` is zero, every table entry is zero and all four enable outputs are low.
- R2: Register 0 holds the enables in bits 3:0. Bit 0 drives `rss_en_o`, bit 1 drives `ip2_en_o`, bit 2 drives `tcp4_en_o` and bit 3 drives `udp4_en_o`. The outputs follow a write on the next cycle, and bits 31:4 read back as zero.
- R3: A write to register 1 with bit 0 set, made while the block is idle, starts an operation. Bit 0 of register 1 then reads 1 for exactly UPD_CYCLES (4) cycles and then clears by itself.
- R4: A command with bit 2 = 1 (key), bit 1 = 0 (write) and index bits 15:8 in 0..9 copies register 2 into key word `idx`. That word appears on `key_o[32*idx+31:32*idx]`, so key byte n is `key_o[8n+7:8n]`.
- R5: A command with bit 2 = 0 (table) and bit 1 = 0 stores register 2 bits 3:0 in table entry `idx` (0..127). The engine reads that entry on `eng_chan_o` when `eng_idx_i` equals `idx`.
- R6: Storage changes only when the busy window completes. While busy reads 1, the key and the table keep their old contents.
- R7: While busy, writes to register 1 and to register 2 are ignored. The operation in progress, the data register and the command fields that read back all stay unchanged.
- R8: A command with bit 1 = 1 (read) loads the selected key word, or the selected table entry zero-extended, into register 2 when the operation completes.
- R9: An index outside the selected memory (key index above 9, table index above 127) still runs the busy window but changes no storage. A read-back with such an index loads zero.
- R10: A write to register 1 with bit 0 clear starts nothing and leaves the command read-back unchanged. Register 1 reads back busy in bit 0, the operation in bit 1, the target in bit 2 and the index in bits 15:8. Writes to register 3 have no effect, and register 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register select: 0 enables, 1 command, 2 data, 3 unused |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected register (combinational) |
| rss_en_o | output | 1 | Global RSS enable |
| ip2_en_o | output | 1 | IP 2-tuple hashing enable |
| tcp4_en_o | output | 1 | TCP/IPv4 4-tuple hashing enable |
| udp4_en_o | output | 1 | UDP/IPv4 4-tuple hashing enable |
| key_o | output | 320 | Hash key, byte n in bits 8n+7:8n |
| eng_idx_i | input | 7 | Engine table read index |
| eng_chan_o | output | 4 | DMA channel stored at `eng_idx_i` |

## Verification
The assertions assume that the bus presents at most one register write per cycle and that the write strobe is never unknown after reset. With those assumptions, the busy window, the frozen data and the frozen command fields follow from the sequencer alone. The stimulus drives every access on the falling edge as a single-cycle strobe. It polls busy before each new command, except in the directed cases that write on purpose during the busy window. Random key indices go up to 11, so out-of-range key commands occur within the legal protocol.

// File: rtl/rss_prog_pkg.sv
package rss_prog_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned IDX_FLD_W = 8;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_CMD    = 2'd1,
    REG_DATA   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // command register bit positions
  localparam int unsigned CMD_BUSY_BIT = 0;
  localparam int unsigned CMD_OP_BIT   = 1;
  localparam int unsigned CMD_TGT_BIT  = 2;
  localparam int unsigned CMD_IDX_LSB  = 8;

  typedef struct packed {
    logic                 rd;   // 1 = read back into data register
    logic                 key;  // 1 = key, 0 = table
    logic [IDX_FLD_W-1:0] idx;
  } cmd_t;
endpackage

// File: rtl/rss_cmd_seq.sv
module rss_cmd_seq
  import rss_prog_pkg::*;
#(
  parameter int unsigned UPD_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic              data_we_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              busy_o,
  output logic              commit_o,
  output cmd_t              cmd_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned CNT_W = (UPD_CYCLES > 1) ? $clog2(UPD_CYCLES) : 1;

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  cmd_t              cmd_q;
  logic [WORD_W-1:0] data_q;

  assign commit_o = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;
  assign cmd_o    = cmd_q;
  assign data_o   = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      data_q <= '0;
    end else if (!busy_q) begin
      if (data_we_i) data_q <= data_i;
      if (cmd_we_i && start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(UPD_CYCLES - 1);
        cmd_q  <= cmd_i;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
      if (cmd_q.rd) data_q <= rd_word_i;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && cmd_we_i && start_i) |=> busy_q); // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q); // R3
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_q); // R3
  AST_DATA_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !commit_o) |=> $stable(data_q)); // R7
  AST_CMD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(cmd_q)); // R7
endmodule

// File: rtl/rss_key_store.sv
module rss_key_store
  import rss_prog_pkg::*;
#(
  parameter int unsigned KEY_WORDS = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_FLD_W-1:0]        idx_i,
  input  logic [WORD_W-1:0]           wdata_i,
  output logic [WORD_W-1:0]           rd_o,
  output logic [KEY_WORDS*WORD_W-1:0] key_o
);
  logic [KEY_WORDS-1:0][WORD_W-1:0] word_q;

  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q[w] <= '0;
      else if (we_i && idx_i == IDX_FLD_W'(w))      word_q[w] <= wdata_i;
    end
  end

  always_comb begin
    rd_o = '0;
    for (int w = 0; w < KEY_WORDS; w++)
      if (idx_i == IDX_FLD_W'(w)) rd_o = word_q[w];
  end

  assign key_o = word_q;

  AST_KEY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(word_q)); // R6
  AST_KEY_OOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i >= IDX_FLD_W'(KEY_WORDS)) |=> $stable(word_q)); // R9
endmodule

// File: rtl/rss_tbl_store.sv
module rss_tbl_store
  import rss_prog_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned CHAN_W = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_FLD_W-1:0] idx_i,
  input  logic [CHAN_W-1:0]    wdata_i,
  output logic [CHAN_W-1:0]    rd_o,
  input  logic [IDX_W-1:0]     eng_idx_i,
  output logic [CHAN_W-1:0]    eng_o
);
  logic [DEPTH-1:0][CHAN_W-1:0] ent_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q[e] <= '0;
      else if (we_i && idx_i == IDX_FLD_W'(e))  ent_q[e] <= wdata_i;
    end
  end

  always_comb begin
    rd_o = '0;
    for (int e = 0; e < DEPTH; e++)
      if (idx_i == IDX_FLD_W'(e)) rd_o = ent_q[e];
  end

  assign eng_o = ent_q[eng_idx_i];

  AST_TBL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ent_q)); // R6
endmodule

// File: rtl/rss_prog_port.sv
module rss_prog_port
  import rss_prog_pkg::*;
#(
  parameter int unsigned KEY_WORDS  = 10,
  parameter int unsigned TBL_DEPTH  = 128,
  parameter int unsigned CHAN_W     = 4,
  parameter int unsigned UPD_CYCLES = 4,
  localparam int unsigned TBL_IDX_W = $clog2(TBL_DEPTH),
  localparam int unsigned KEY_W     = KEY_WORDS * WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           bus_addr_i,
  input  logic                 bus_we_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 rss_en_o,
  output logic                 ip2_en_o,
  output logic                 tcp4_en_o,
  output logic                 udp4_en_o,
  output logic [KEY_W-1:0]     key_o,
  input  logic [TBL_IDX_W-1:0] eng_idx_i,
  output logic [CHAN_W-1:0]    eng_chan_o
);
  reg_sel_e          sel;
  logic [3:0]        en_q;
  logic              busy, commit;
  cmd_t              cmd_new, cmd_cur;
  logic [WORD_W-1:0] data_cur, key_rd, rd_word;
  logic [CHAN_W-1:0] tbl_rd;
  logic              key_we, tbl_we;

  assign sel     = reg_sel_e'(bus_addr_i);
  assign cmd_new = '{rd:  bus_wdata_i[CMD_OP_BIT],
                     key: bus_wdata_i[CMD_TGT_BIT],
                     idx: bus_wdata_i[CMD_IDX_LSB +: IDX_FLD_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           en_q <= '0;
    else if (bus_we_i && sel == REG_ENABLE) en_q <= bus_wdata_i[3:0];
  end

  assign {udp4_en_o, tcp4_en_o, ip2_en_o, rss_en_o} = en_q;

  rss_cmd_seq #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (bus_we_i && sel == REG_CMD),
    .start_i   (bus_wdata_i[CMD_BUSY_BIT]),
    .cmd_i     (cmd_new),
    .data_we_i (bus_we_i && sel == REG_DATA),
    .data_i    (bus_wdata_i),
    .rd_word_i (rd_word),
    .busy_o    (busy),
    .commit_o  (commit),
    .cmd_o     (cmd_cur),
    .data_o    (data_cur)
  );

  assign key_we  = commit && !cmd_cur.rd &&  cmd_cur.key;
  assign tbl_we  = commit && !cmd_cur.rd && !cmd_cur.key;
  assign rd_word = cmd_cur.key ? key_rd : WORD_W'(tbl_rd);

  rss_key_store #(.KEY_WORDS(KEY_WORDS)) u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (key_we),
    .idx_i   (cmd_cur.idx),
    .wdata_i (data_cur),
    .rd_o    (key_rd),
    .key_o   (key_o)
  );

  rss_tbl_store #(.DEPTH(TBL_DEPTH), .CHAN_W(CHAN_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we),
    .idx_i     (cmd_cur.idx),
    .wdata_i   (data_cur[CHAN_W-1:0]),
    .rd_o      (tbl_rd),
    .eng_idx_i (eng_idx_i),
    .eng_o     (eng_chan_o)
  );

  always_comb begin
    unique case (sel)
      REG_ENABLE: bus_rdata_o = {28'b0, en_q};
      REG_CMD:    bus_rdata_o = {16'b0, cmd_cur.idx, 5'b0, cmd_cur.key, cmd_cur.rd, busy};
      REG_DATA:   bus_rdata_o = data_cur;
      default:    bus_rdata_o = '0;
    endcase
  end

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && sel == REG_ENABLE) |=> $stable(en_q)); // R2
  AST_STORE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy) |=> ($stable(key_o) && $stable(eng_chan_o) || $changed(eng_idx_i))); // R6
endmodule

// File: tb/rss_prog_port_tb_top.sv
module rss_prog_port_tb_top;
  localparam int KW = 10, TD = 128, UPD = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd3;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rss_en, ip2_en, tcp4_en, udp4_en;
  logic [319:0] key;
  logic [6:0]  eng_idx = '0;
  logic [3:0]  eng_chan;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] key_m [KW];
  logic [3:0]  tbl_m [TD];

  always #2.5 clk = ~clk;

  rss_prog_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .rss_en_o(rss_en),
    .ip2_en_o(ip2_en), .tcp4_en_o(tcp4_en), .udp4_en_o(udp4_en), .key_o(key),
    .eng_idx_i(eng_idx), .eng_chan_o(eng_chan));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata; bus_addr = 2'd3;
  endtask

  function automatic logic [31:0] cmd_word(input bit is_key, input bit is_rd, input int idx);
    return {16'b0, 8'(idx), 5'b0, is_key, is_rd, 1'b1};
  endfunction

  function automatic logic [31:0] model_read(input bit is_key, input int idx);
    if (is_key) return (idx < KW) ? key_m[idx] : 32'h0;
    return (idx < TD) ? {28'b0, tbl_m[idx]} : 32'h0;
  endfunction

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(2'd1, v);
    while (v[0] && n < 100) begin
      n++;
      @(negedge clk);
      rd(2'd1, v);
    end
  endtask

  task automatic do_op(input bit is_key, input bit is_rd, input int idx, input logic [31:0] d);
    int n;
    wr(2'd2, d);
    wr(2'd1, cmd_word(is_key, is_rd, idx));
    wait_idle(n);
    if (!is_rd) begin
      if (is_key && idx < KW) key_m[idx] = d;
      if (!is_key && idx < TD) tbl_m[idx] = d[3:0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < KW; i++) key_m[i] = '0;
    for (int i = 0; i < TD; i++) tbl_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg", v, 0); end
    chk("R1 key", {31'b0, |key}, 0);
    chk("R1 enables", {28'b0, udp4_en, tcp4_en, ip2_en, rss_en}, 0);
    eng_idx = 7'd77; #0.5; chk("R1 table", {28'b0, eng_chan}, 0);

    // R2 enables
    wr(2'd0, 32'hFFFF_FFF5);
    rd(2'd0, v); chk("R2 readback", v, 32'h5);
    chk("R2 outputs", {28'b0, udp4_en, tcp4_en, ip2_en, rss_en}, 32'h5);
    wr(2'd0, 32'h0000_000A);
    chk("R2 outputs", {28'b0, udp4_en, tcp4_en, ip2_en, rss_en}, 32'hA);

    // R3 busy window, R6 no early update, R5 table write
    wr(2'd2, 32'h0000_0009);
    wr(2'd1, cmd_word(0, 0, 7));
    eng_idx = 7'd7; #0.5;
    chk("R6 table before commit", {28'b0, eng_chan}, 0);
    wait_idle(n);
    chk("R3 busy cycles", n, UPD);
    tbl_m[7] = 4'h9;
    chk("R5 table write", {28'b0, eng_chan}, 32'h9);

    // R4 key packing
    do_op(1, 0, 0, 32'h4433_2211);
    chk("R4 byte0", {24'b0, key[7:0]}, 32'h11);
    chk("R4 byte3", {24'b0, key[31:24]}, 32'h44);
    do_op(1, 0, 9, 32'hAB00_0000);
    chk("R4 byte39", {24'b0, key[319:312]}, 32'hAB);

    // R7 writes while busy ignored
    wr(2'd2, 32'hCAFE_F00D);
    wr(2'd1, cmd_word(1, 0, 3));
    wr(2'd2, 32'h1234_5678);
    wr(2'd1, cmd_word(0, 0, 5));
    wait_idle(n);
    key_m[3] = 32'hCAFE_F00D;
    chk("R7 key target kept", key[3*32 +: 32], 32'hCAFE_F00D);
    eng_idx = 7'd5; #0.5;
    chk("R7 table untouched", {28'b0, eng_chan}, 0);
    rd(2'd2, v); chk("R7 data frozen", v, 32'hCAFE_F00D);
    rd(2'd1, v); chk("R7 cmd fields", v, 32'h0000_0304);

    // R10 no start, unused register
    wr(2'd1, 32'h0000_0506);
    rd(2'd1, v); chk("R10 no start", v, 32'h0000_0304);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R10 reg3", v, 0);

    // R9 out of range
    do_op(1, 0, 10, 32'hDEAD_BEEF);
    for (int i = 0; i < KW; i++) chk("R9 key unchanged", key[i*32 +: 32], key_m[i]);
    do_op(1, 1, 11, 32'h5555_5555);
    rd(2'd2, v); chk("R9 oor read zero", v, 0);

    // R8 read-back directed
    do_op(1, 1, 3, 32'h0);
    rd(2'd2, v); chk("R8 key read", v, 32'hCAFE_F00D);
    do_op(0, 1, 7, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R8 table read", v, 32'h9);

    // random mix
    for (int it = 0; it < 300; it++) begin
      bit is_key = $urandom_range(0, 1);
      bit is_rd  = ($urandom_range(0, 3) == 0);
      int idx    = is_key ? $urandom_range(0, 11) : $urandom_range(0, 127);
      logic [31:0] d = $urandom();
      do_op(is_key, is_rd, idx, d);
      if (is_rd) begin
        rd(2'd2, v); chk("R8 random read", v, model_read(is_key, idx));
      end
    end
    for (int i = 0; i < KW; i++) chk("R4 random key", key[i*32 +: 32], key_m[i]);
    for (int i = 0; i < TD; i++) begin
      eng_idx = 7'(i); #0.5;
      chk("R5 random table", {28'b0, eng_chan}, {28'b0, tbl_m[i]});
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule